// File: doc/BRIEF.md
# Memory Request Partition Label Selector

This block attaches a partition identifier and a performance-monitoring group to each memory request as it leaves the core. It is purely combinational. Each request carries its privilege level (0 to 3) and two class bits: one for a matrix-unit load or store, and one for a vector, SIMD/FP or vector-prefetch access. A separate input tells whether streaming mode is active.

A request counts as streaming-class when it is a matrix-unit load/store, or a vector access while streaming mode is on. A streaming-class request takes the dedicated streaming label when the override is in force. The override is in force when the matrix unit is shared. When the matrix unit is private, a parameter decides. Every other request takes the label of its own privilege level. All labels depend on a global partitioning enable.

The block also says whether the chosen partition identifier is virtual and must be translated further downstream. That depends on the level and on the hypervisor control bits. Requests move through a valid/ready pair that is wired straight through. The label is valid in the same cycle as the request, and back-pressure from the consumer reaches the producer with no delay and no storage.

Top module: `mreq_label_sel`

## Requirements
- R1: With `part_en`=1 and the override in force (`SHARED_UNIT`=1, or `SHARED_UNIT`=0 with `PRIVATE_OVERRIDE`=1), a streaming-class request outputs `sm_partid` and `sm_pmg`. Streaming-class means `req_matrix_ls`=1, or `req_vector`=1 with `streaming_on`=1.
- R2: With `part_en`=1, a request that is not streaming-class outputs the label of level `req_level`. That label is taken from slice `req_level` of `lvl_partid` (bits `[L*PARTID_W +: PARTID_W]`) and of `lvl_pmg` (bits `[L*PMG_W +: PMG_W]`). A vector access with `streaming_on`=0 falls in this case.
- R3: With `part_en`=0, the outputs are `lbl_partid`=0, `lbl_pmg`=0 and `lbl_virtual`=0, whatever the other inputs are.
- R4: For level 0 with `part_en`=1, `lbl_virtual` = `hyp_active` AND NOT(`hyp_e2h` AND `hyp_tge`) AND `vmap_en_l0`.
- R5: For level 1 with `part_en`=1, `lbl_virtual` = `hyp_active` AND `vmap_en_l1`.
- R6: For levels 2 and 3, `lbl_virtual` is 0.
- R7: With `SHARED_UNIT`=0 and `PRIVATE_OVERRIDE`=0, a streaming-class request with `part_en`=1 outputs the label of its own level, not the streaming label.
- R8: `lbl_valid` equals `req_valid` and `req_ready` equals `lbl_ready` in the same cycle. The block holds no state, so a stalled request keeps its label for as long as the inputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (equals lbl_ready) |
| req_level | input | LVL_W (2) | Privilege level of the request |
| req_matrix_ls | input | 1 | Request is a matrix-unit load/store |
| req_vector | input | 1 | Request is a vector, SIMD/FP or vector-prefetch access |
| streaming_on | input | 1 | Streaming mode active |
| lvl_partid | input | N_LEVELS*PARTID_W | Per-level partition IDs, level L at slice L |
| lvl_pmg | input | N_LEVELS*PMG_W | Per-level monitoring groups, level L at slice L |
| sm_partid | input | PARTID_W | Streaming-mode partition ID |
| sm_pmg | input | PMG_W | Streaming-mode monitoring group |
| part_en | input | 1 | Global partitioning enable |
| hyp_active | input | 1 | Level 2 implemented and enabled in the current security state |
| hyp_e2h | input | 1 | Hypervisor host-mode bit |
| hyp_tge | input | 1 | Hypervisor trap-general bit |
| vmap_en_l0 | input | 1 | Virtual mapping enable for level 0 |
| vmap_en_l1 | input | 1 | Virtual mapping enable for level 1 |
| lbl_valid | output | 1 | Label present |
| lbl_ready | input | 1 | Consumer accepts the label |
| lbl_partid | output | PARTID_W | Chosen partition ID |
| lbl_pmg | output | PMG_W | Chosen monitoring group |
| lbl_virtual | output | 1 | Partition ID is virtual |

## Verification
The assertions check the following rules on every evaluation:
- the disabled-zero rule;
- the physical-only rule for levels 2 and 3;
- the level-1 virtual rule;
- the handshake pass-through;
- the choice between the streaming label and the per-level label for the configuration in use.

The level-0 rule, with its joint dependence on host mode and the trap bit, is shown only by the bench's sweep. So is the private-unit variant with the override off, because it needs a second instance.

// File: rtl/mreq_label_pkg.sv
package mreq_label_pkg;
  localparam int LVL_USER   = 0;
  localparam int LVL_KERNEL = 1;

  function automatic logic stream_class(input logic matrix_ls, input logic vector,
                                        input logic streaming);
    return matrix_ls | (vector & streaming);
  endfunction
endpackage

// File: rtl/mreq_label_class.sv
module mreq_label_class #(
  parameter bit SHARED_UNIT      = 1'b1,
  parameter bit PRIVATE_OVERRIDE = 1'b1
) (
  input  logic matrix_ls,
  input  logic vector,
  input  logic streaming,
  output logic use_stream_lbl
);
  import mreq_label_pkg::*;
  localparam bit OVR_EN = SHARED_UNIT || PRIVATE_OVERRIDE;

  assign use_stream_lbl = stream_class(matrix_ls, vector, streaming) & OVR_EN;
endmodule

// File: rtl/mreq_label_levelmux.sv
module mreq_label_levelmux #(
  parameter int N_LEVELS = 4,
  parameter int PARTID_W = 16,
  parameter int PMG_W    = 8,
  localparam int LVL_W   = $clog2(N_LEVELS)
) (
  input  logic [LVL_W-1:0]            level,
  input  logic [N_LEVELS*PARTID_W-1:0] partid_flat,
  input  logic [N_LEVELS*PMG_W-1:0]    pmg_flat,
  output logic [PARTID_W-1:0]         partid,
  output logic [PMG_W-1:0]            pmg
);
  logic [PARTID_W-1:0] partid_arr [N_LEVELS];
  logic [PMG_W-1:0]    pmg_arr    [N_LEVELS];

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_unpack
    assign partid_arr[g] = partid_flat[g*PARTID_W +: PARTID_W];
    assign pmg_arr[g]    = pmg_flat[g*PMG_W +: PMG_W];
  end

  assign partid = partid_arr[level];
  assign pmg    = pmg_arr[level];
endmodule

// File: rtl/mreq_label_virt.sv
module mreq_label_virt #(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] level,
  input  logic             hyp_active,
  input  logic             hyp_e2h,
  input  logic             hyp_tge,
  input  logic             vmap_en_l0,
  input  logic             vmap_en_l1,
  output logic             is_virtual
);
  import mreq_label_pkg::*;
  logic host_mode;
  assign host_mode = hyp_e2h & hyp_tge;

  always_comb begin
    if (int'(level) == LVL_USER)        is_virtual = hyp_active & ~host_mode & vmap_en_l0;
    else if (int'(level) == LVL_KERNEL) is_virtual = hyp_active & vmap_en_l1;
    else                                is_virtual = 1'b0;
  end
endmodule

// File: rtl/mreq_label_sel.sv
module mreq_label_sel #(
  parameter int N_LEVELS         = 4,
  parameter int PARTID_W         = 16,
  parameter int PMG_W            = 8,
  parameter bit SHARED_UNIT      = 1'b1,
  parameter bit PRIVATE_OVERRIDE = 1'b1,
  localparam int LVL_W           = $clog2(N_LEVELS)
) (
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [LVL_W-1:0]             req_level,
  input  logic                         req_matrix_ls,
  input  logic                         req_vector,
  input  logic                         streaming_on,
  input  logic [N_LEVELS*PARTID_W-1:0] lvl_partid,
  input  logic [N_LEVELS*PMG_W-1:0]    lvl_pmg,
  input  logic [PARTID_W-1:0]          sm_partid,
  input  logic [PMG_W-1:0]             sm_pmg,
  input  logic                         part_en,
  input  logic                         hyp_active,
  input  logic                         hyp_e2h,
  input  logic                         hyp_tge,
  input  logic                         vmap_en_l0,
  input  logic                         vmap_en_l1,
  output logic                         lbl_valid,
  input  logic                         lbl_ready,
  output logic [PARTID_W-1:0]          lbl_partid,
  output logic [PMG_W-1:0]             lbl_pmg,
  output logic                         lbl_virtual
);
  logic                use_sm;
  logic [PARTID_W-1:0] lvl_sel_partid;
  logic [PMG_W-1:0]    lvl_sel_pmg;
  logic                virt_raw;

  mreq_label_class #(.SHARED_UNIT(SHARED_UNIT), .PRIVATE_OVERRIDE(PRIVATE_OVERRIDE)) u_class (
    .matrix_ls(req_matrix_ls), .vector(req_vector), .streaming(streaming_on),
    .use_stream_lbl(use_sm));

  mreq_label_levelmux #(.N_LEVELS(N_LEVELS), .PARTID_W(PARTID_W), .PMG_W(PMG_W)) u_mux (
    .level(req_level), .partid_flat(lvl_partid), .pmg_flat(lvl_pmg),
    .partid(lvl_sel_partid), .pmg(lvl_sel_pmg));

  mreq_label_virt #(.LVL_W(LVL_W)) u_virt (
    .level(req_level), .hyp_active(hyp_active), .hyp_e2h(hyp_e2h), .hyp_tge(hyp_tge),
    .vmap_en_l0(vmap_en_l0), .vmap_en_l1(vmap_en_l1), .is_virtual(virt_raw));

  always_comb begin
    if (!part_en) begin
      lbl_partid = '0;
      lbl_pmg    = '0;
    end else if (use_sm) begin
      lbl_partid = sm_partid;
      lbl_pmg    = sm_pmg;
    end else begin
      lbl_partid = lvl_sel_partid;
      lbl_pmg    = lvl_sel_pmg;
    end
  end

  assign lbl_virtual = part_en & virt_raw;
  assign lbl_valid   = req_valid;
  assign req_ready   = lbl_ready;
endmodule

// File: rtl/mreq_label_sel_chk.sv
module mreq_label_sel_chk #(
  parameter int N_LEVELS         = 4,
  parameter int PARTID_W         = 16,
  parameter int PMG_W            = 8,
  parameter bit SHARED_UNIT      = 1'b1,
  parameter bit PRIVATE_OVERRIDE = 1'b1,
  localparam int LVL_W           = $clog2(N_LEVELS)
) (
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [LVL_W-1:0]             req_level,
  input logic                         req_matrix_ls,
  input logic                         req_vector,
  input logic                         streaming_on,
  input logic [N_LEVELS*PARTID_W-1:0] lvl_partid,
  input logic [N_LEVELS*PMG_W-1:0]    lvl_pmg,
  input logic [PARTID_W-1:0]          sm_partid,
  input logic [PMG_W-1:0]             sm_pmg,
  input logic                         part_en,
  input logic                         hyp_active,
  input logic                         vmap_en_l1,
  input logic                         lbl_valid,
  input logic                         lbl_ready,
  input logic [PARTID_W-1:0]          lbl_partid,
  input logic [PMG_W-1:0]             lbl_pmg,
  input logic                         lbl_virtual
);
  localparam bit OVR_EN = SHARED_UNIT || PRIVATE_OVERRIDE;
  logic scls;
  assign scls = req_matrix_ls | (req_vector & streaming_on);

  always_comb begin
    AST_DISABLED_ZERO: assert (part_en || (lbl_partid == '0 && lbl_pmg == '0 && !lbl_virtual))
      else $error("disabled label not zero"); // R3
    AST_HIGH_LEVEL_PHYS: assert (int'(req_level) < 2 || !lbl_virtual)
      else $error("virtual flag at level 2/3"); // R6
    AST_KERNEL_VIRT: assert (!(part_en && int'(req_level) == 1) || lbl_virtual == (hyp_active & vmap_en_l1))
      else $error("level-1 virtual flag wrong"); // R5
    AST_HANDSHAKE_PASS: assert (lbl_valid == req_valid && req_ready == lbl_ready)
      else $error("handshake not passed through"); // R8
    AST_STREAM_SRC: assert (!(part_en && scls && OVR_EN) || (lbl_partid == sm_partid && lbl_pmg == sm_pmg))
      else $error("streaming label not chosen"); // R1
    AST_LEVEL_SRC: assert (!(part_en && !(scls && OVR_EN)) ||
                           (lbl_partid == lvl_partid[int'(req_level)*PARTID_W +: PARTID_W] &&
                            lbl_pmg == lvl_pmg[int'(req_level)*PMG_W +: PMG_W]))
      else $error("per-level label not chosen"); // R2
  end
endmodule

bind mreq_label_sel mreq_label_sel_chk #(
  .N_LEVELS(N_LEVELS), .PARTID_W(PARTID_W), .PMG_W(PMG_W),
  .SHARED_UNIT(SHARED_UNIT), .PRIVATE_OVERRIDE(PRIVATE_OVERRIDE)
) u_chk (
  .req_valid(req_valid), .req_ready(req_ready), .req_level(req_level),
  .req_matrix_ls(req_matrix_ls), .req_vector(req_vector), .streaming_on(streaming_on),
  .lvl_partid(lvl_partid), .lvl_pmg(lvl_pmg), .sm_partid(sm_partid), .sm_pmg(sm_pmg),
  .part_en(part_en), .hyp_active(hyp_active), .vmap_en_l1(vmap_en_l1),
  .lbl_valid(lbl_valid), .lbl_ready(lbl_ready), .lbl_partid(lbl_partid),
  .lbl_pmg(lbl_pmg), .lbl_virtual(lbl_virtual));

// File: tb/test_mreq_label_sel.sv
module test_mreq_label_sel;
  localparam int NL = 4, PW = 16, GW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic req_valid, lbl_ready, mx, vec, strm, en, hyp, e2h, tge, vm0, vm1;
  logic [1:0] lvl;
  logic [NL*PW-1:0] lp;
  logic [NL*GW-1:0] lg;
  logic [PW-1:0] smp;
  logic [GW-1:0] smg;
  logic rdy_s, val_s, virt_s, rdy_p, val_p, virt_p;
  logic [PW-1:0] pid_s, pid_p;
  logic [GW-1:0] pmg_s, pmg_p;

  int checks = 0, errors = 0;
  bit done = 0;

  mreq_label_sel i_mreq_label_sel (
    .req_valid(req_valid), .req_ready(rdy_s), .req_level(lvl), .req_matrix_ls(mx),
    .req_vector(vec), .streaming_on(strm), .lvl_partid(lp), .lvl_pmg(lg),
    .sm_partid(smp), .sm_pmg(smg), .part_en(en), .hyp_active(hyp), .hyp_e2h(e2h),
    .hyp_tge(tge), .vmap_en_l0(vm0), .vmap_en_l1(vm1), .lbl_valid(val_s),
    .lbl_ready(lbl_ready), .lbl_partid(pid_s), .lbl_pmg(pmg_s), .lbl_virtual(virt_s));

  mreq_label_sel #(.SHARED_UNIT(1'b0), .PRIVATE_OVERRIDE(1'b0)) i_mreq_label_sel_priv (
    .req_valid(req_valid), .req_ready(rdy_p), .req_level(lvl), .req_matrix_ls(mx),
    .req_vector(vec), .streaming_on(strm), .lvl_partid(lp), .lvl_pmg(lg),
    .sm_partid(smp), .sm_pmg(smg), .part_en(en), .hyp_active(hyp), .hyp_e2h(e2h),
    .hyp_tge(tge), .vmap_en_l0(vm0), .vmap_en_l1(vm1), .lbl_valid(val_p),
    .lbl_ready(lbl_ready), .lbl_partid(pid_p), .lbl_pmg(pmg_p), .lbl_virtual(virt_p));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      lp[l*PW +: PW] = 16'h1000 + 16'(l * 16'h0111);
      lg[l*GW +: GW] = 8'h20 + 8'(l * 3);
    end
    {req_valid, lbl_ready, mx, vec, strm, en, hyp, e2h, tge, vm0, vm1} = '0;
    lvl = '0; smp = 16'hA5C3; smg = 8'h5A;
    @(negedge clk); #1;
    chk("R3 idle partid", 32'(pid_s), 0);
    chk("R3 idle pmg", 32'(pmg_s), 0);
    chk("R3 idle virtual", 32'(virt_s), 0);
    chk("R8 idle valid", 32'(val_s), 0);

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_valid = i[0]; lbl_ready = i[1];
      #1;
      chk("R8 valid pass", 32'(val_s), 32'(i[0]));
      chk("R8 ready pass", 32'(rdy_s), 32'(i[1]));
      chk("R8 priv valid pass", 32'(val_p), 32'(i[0]));
    end

    for (int i = 0; i < 2048; i++) begin
      logic sc, e_v;
      logic [PW-1:0] e_ps, e_pp;
      logic [GW-1:0] e_gs, e_gp;
      int L;
      @(negedge clk);
      L = i & 3;
      lvl = 2'(L);
      {mx, vec, strm, en, hyp, e2h, tge, vm0, vm1} = 9'(i >> 2);
      smp = 16'hA5C3 ^ 16'(i);
      smg = 8'h5A ^ 8'(i >> 3);
      #1;
      sc = mx | (vec & strm);
      if (L == 0)      e_v = hyp & ~(e2h & tge) & vm0;
      else if (L == 1) e_v = hyp & vm1;
      else             e_v = 1'b0;
      e_pp = lp[L*PW +: PW];
      e_gp = lg[L*GW +: GW];
      e_ps = sc ? smp : e_pp;
      e_gs = sc ? smg : e_gp;
      if (!en) begin
        chk("R3 partid zero", 32'(pid_s), 0);
        chk("R3 pmg zero", 32'(pmg_s), 0);
        chk("R3 virtual zero", 32'(virt_s), 0);
        chk("R3 priv partid zero", 32'(pid_p), 0);
      end else begin
        if (sc) begin
          chk("R1 stream partid", 32'(pid_s), 32'(e_ps));
          chk("R1 stream pmg", 32'(pmg_s), 32'(e_gs));
          chk("R7 private level partid", 32'(pid_p), 32'(e_pp));
          chk("R7 private level pmg", 32'(pmg_p), 32'(e_gp));
        end else begin
          chk("R2 level partid", 32'(pid_s), 32'(e_pp));
          chk("R2 level pmg", 32'(pmg_s), 32'(e_gp));
          chk("R2 priv level partid", 32'(pid_p), 32'(e_pp));
        end
        if (L == 0)      chk("R4 level0 virtual", 32'(virt_s), 32'(e_v));
        else if (L == 1) chk("R5 level1 virtual", 32'(virt_s), 32'(e_v));
        else             chk("R6 high level physical", 32'(virt_s), 0);
        chk("R4 R5 R6 priv virtual", 32'(virt_p), 32'(e_v));
      end
    end

    @(negedge clk);
    {req_valid, lbl_ready} = 2'b10;
    lvl = 2'd2; {mx, vec, strm, en} = 4'b0001;
    #1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R8 stalled label held", 32'(pid_s), 32'(lp[2*PW +: PW]));
      chk("R8 stalled ready low", 32'(rdy_s), 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule